// File: doc/BRIEF.md
# Byte File-Register Execute Unit

This block is the execute stage of a small accumulator-style 8-bit controller. Each cycle it may accept one 16-bit instruction. The upper byte selects the operation and the lower byte names an 8-bit file address. The unit reads that file location through a combinational read port, combines the value with the working register (WREG), and writes the result back. The result goes to the file through a one-cycle write strobe, to WREG, or to both. The unit also keeps a 4-bit flag register and updates it.

One group of instructions tests a result and can ask for the following instruction to be thrown away. When that test succeeds, the unit raises a skip pulse in the execute cycle. In the next cycle it marks an extra cycle, and whatever instruction is presented then is discarded as if it were a no-op. Fetch, table moves, the multiplier and banking live elsewhere. Any opcode this unit does not know raises an unimplemented pulse and changes nothing.

Top module: `byte_exec_unit`

## Requirements
- R1: While reset is held low, and on its release, WREG is 0, the flag register is 0, the extra-cycle output is 0 and no file write is strobed. The flag bits are C at bit 0, DC at bit 1, Z at bit 2 and OV at bit 3.
- R2: The instruction acts only when `instr_valid` is high. Bits 15:8 are the opcode and bits 7:0 are the file address, which is driven straight to `file_rd_addr`. An idle cycle changes no state.
- R3: In the d-form opcodes, bit 8 is the destination. A 1 strobes a file write of the result to address f, and a 0 loads the result into WREG.
- R4: The add and subtract opcodes update C, DC, Z and OV. They are add 0x0E/0x0F (f+W), add with carry 0x10/0x11 (f+W+C), subtract 0x04/0x05 (f-W) and subtract with borrow 0x02/0x03 (f-W-!C). For subtraction, C=1 and DC=1 mean that no borrow occurred.
- R5: AND 0x0A/0x0B, inclusive OR 0x08/0x09 and complement 0x12/0x13 update only Z. Nibble swap 0x1C/0x1D updates no flag.
- R6: Increment 0x14/0x15 (f+1) and decrement 0x06/0x07 (f-1) update C, DC, Z and OV by the same rules as R4.
- R7: Rotate left through carry 0x1A/0x1B and rotate right through carry 0x18/0x19 shift C in and the outgoing bit into C, and update only C. Rotate left 0x22/0x23 and rotate right 0x20/0x21 wrap within the byte and update no flag.
- R8: Skip opcodes change no flag. Decrement-skip-if-zero 0x16/0x17, decrement-skip-if-nonzero 0x26/0x27, increment-skip-if-zero 0x1E/0x1F and increment-skip-if-nonzero 0x24/0x25 write f±1 by the destination bit. The unsigned compares write nothing: equal 0x31, f>W 0x32, f<W 0x30. The skip output pulses in the execute cycle exactly when the condition holds.
- R9: In the cycle after a skip pulse, the extra-cycle output is high. The instruction presented in that cycle is discarded: no write, no skip, no unimplemented pulse and no state change.
- R10: In the s-form opcodes, bit 8 is s. Both s values write the file, and s=0 also loads WREG. Clear 0x28/0x29 writes 0 and set 0x2A/0x2B writes all ones, with no flags. Negate 0x2C/0x2D writes 0-W and updates C, DC, Z and OV.
- R11: Opcode 0x01 copies WREG to file f and changes no flag. Opcode 0x00 does nothing.
- R12: When f equals the WREG address (parameter, default 0x0A), WREG is used as the operand. Any file-destined result goes into WREG and no file write is strobed.
- R13: Opcodes outside R3 to R11 (for example 0x0C, 0x33, 0x34, 0x40, 0xFF) raise `unimpl_o` and change no state. They strobe no write and raise no skip.
- R14: Decimal adjust 0x2E/0x2F is an s-form opcode. It first adds 6 if W[3:0] > 9 or DC is set. It then adds 0x60 if the upper nibble is > 9, C is set, or the first step carried out. C becomes 1 exactly when the second step fires. No other flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 16 | Instruction word: opcode in 15:8, file address in 7:0 |
| file_rd_addr | output | 8 | File read address |
| file_rd_data | input | 8 | File read data, combinational |
| file_wr_en | output | 1 | File write strobe |
| file_wr_addr | output | 8 | File write address |
| file_wr_data | output | 8 | File write data |
| wreg_o | output | 8 | Current WREG |
| status_o | output | 4 | Flags {OV, Z, DC, C} |
| skip_o | output | 1 | Taken skip in this execute cycle |
| busy_o | output | 1 | Extra cycle: incoming instruction discarded |
| unimpl_o | output | 1 | Unknown opcode presented |

## Verification
The bench goes after the flag edges: carry out of 0xFF+1, borrow from 0-1, signed overflow at 0x7F+1 and at the negation of 0x80, and a half carry without a full carry. A design with a wrong carry sense on subtraction would show inverted C and DC here. It also presents a taken skip followed by another skip, a write, or an unknown opcode. A unit that failed to discard the second instruction would strobe writes, raise a second skip, or stretch the extra cycle. Compares with f equal to WREG show whether a greater-than or less-than test leaks its equality case. Operations addressed at the WREG location show whether the result was wrongly strobed onto the file port instead of being looped into WREG.

// File: rtl/bx_pkg.sv
package bx_pkg;

   localparam int INSTR_W = 16;
   localparam int ADDR_W  = 8;
   localparam int OPC_W   = INSTR_W - ADDR_W;

   typedef enum logic [4:0] {
      OP_NOP, OP_MOVWF,
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB,
      OP_AND, OP_IOR, OP_COM, OP_SWAP,
      OP_INC, OP_DEC,
      OP_RLC, OP_RRC, OP_RLN, OP_RRN,
      OP_DECSZ, OP_DECSNZ, OP_INCSZ, OP_INCSNZ,
      OP_CPEQ, OP_CPGT, OP_CPLT,
      OP_CLR, OP_SET, OP_NEG, OP_DAW,
      OP_BAD
   } bx_op_e;

   // how the destination/s bit is interpreted
   typedef enum logic [1:0] {
      DST_NONE,   // nothing written
      DST_DFORM,  // bit8: 1 file, 0 WREG
      DST_SFORM,  // file always, WREG when bit8 is 0
      DST_FILE    // file only
   } bx_dst_e;

   typedef struct packed {
      logic ov;
      logic z;
      logic dc;
      logic c;
   } bx_flags_t;

endpackage

// File: rtl/bx_adder.sv
module bx_adder #(
   parameter int DW     = 8,
   parameter int NIB    = DW / 2,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          cin,
   output logic [DW-1:0] sum,
   output logic          cout,
   output logic          hcout,
   output logic          ovf
);

   generate
      if (RIPPLE) begin : g_ripple
         logic [DW:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < DW; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
         end
         assign cout  = cy[DW];
         assign hcout = cy[NIB];
         assign ovf   = cy[DW] ^ cy[DW-1];
      end else begin : g_flat
         logic [DW:0]  full;
         logic [NIB:0] low;
         assign full  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
         assign low   = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
         assign sum   = full[DW-1:0];
         assign cout  = full[DW];
         assign hcout = low[NIB];
         assign ovf   = (a[DW-1] == b[DW-1]) && (full[DW-1] != a[DW-1]);
      end
   endgenerate

endmodule

// File: rtl/bx_decode.sv
module bx_decode
   import bx_pkg::*;
#(
   parameter bit HAS_DAW = 1'b1
) (
   input  logic [OPC_W-1:0] opc,
   output bx_op_e           op,
   output bx_dst_e          dst
);

   logic daw_ok;

   generate
      if (HAS_DAW) begin : g_daw_on
         assign daw_ok = 1'b1;
      end else begin : g_daw_off
         assign daw_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      op  = OP_BAD;
      dst = DST_NONE;
      case (opc[OPC_W-1:1])
         7'b0000_000: begin
            op  = opc[0] ? OP_MOVWF : OP_NOP;
            dst = opc[0] ? DST_FILE : DST_NONE;
         end
         7'b0000_001: begin op = OP_SUBB;   dst = DST_DFORM; end
         7'b0000_010: begin op = OP_SUB;    dst = DST_DFORM; end
         7'b0000_011: begin op = OP_DEC;    dst = DST_DFORM; end
         7'b0000_100: begin op = OP_IOR;    dst = DST_DFORM; end
         7'b0000_101: begin op = OP_AND;    dst = DST_DFORM; end
         7'b0000_111: begin op = OP_ADD;    dst = DST_DFORM; end
         7'b0001_000: begin op = OP_ADDC;   dst = DST_DFORM; end
         7'b0001_001: begin op = OP_COM;    dst = DST_DFORM; end
         7'b0001_010: begin op = OP_INC;    dst = DST_DFORM; end
         7'b0001_011: begin op = OP_DECSZ;  dst = DST_DFORM; end
         7'b0001_100: begin op = OP_RRC;    dst = DST_DFORM; end
         7'b0001_101: begin op = OP_RLC;    dst = DST_DFORM; end
         7'b0001_110: begin op = OP_SWAP;   dst = DST_DFORM; end
         7'b0001_111: begin op = OP_INCSZ;  dst = DST_DFORM; end
         7'b0010_000: begin op = OP_RRN;    dst = DST_DFORM; end
         7'b0010_001: begin op = OP_RLN;    dst = DST_DFORM; end
         7'b0010_010: begin op = OP_INCSNZ; dst = DST_DFORM; end
         7'b0010_011: begin op = OP_DECSNZ; dst = DST_DFORM; end
         7'b0010_100: begin op = OP_CLR;    dst = DST_SFORM; end
         7'b0010_101: begin op = OP_SET;    dst = DST_SFORM; end
         7'b0010_110: begin op = OP_NEG;    dst = DST_SFORM; end
         7'b0010_111: begin
            if (daw_ok) begin
               op  = OP_DAW;
               dst = DST_SFORM;
            end
         end
         7'b0011_000: op = opc[0] ? OP_CPEQ : OP_CPLT;
         7'b0011_001: begin
            if (!opc[0]) op = OP_CPGT;
         end
         default: begin
            op  = OP_BAD;
            dst = DST_NONE;
         end
      endcase
   end

endmodule

// File: rtl/bx_alu.sv
module bx_alu
   import bx_pkg::*;
#(
   parameter int DW     = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  bx_op_e        op,
   input  logic [DW-1:0] fv,
   input  logic [DW-1:0] wv,
   input  logic          c_in,
   input  logic          dc_in,
   output logic [DW-1:0] res,
   output bx_flags_t     flg,
   output bx_flags_t     upd,
   output logic          skip_cond
);

   localparam int NIB = DW / 2;
   localparam logic [NIB-1:0] NIB_MAX = NIB'(9);
   localparam logic [DW:0]    ADJ_LO  = (DW+1)'(6);
   localparam logic [DW:0]    ADJ_HI  = (DW+1)'(6) << NIB;

   logic [DW-1:0] add_a, add_b, sum;
   logic          add_ci, cout, hcout, ovf;

   logic          lo_adj, hi_adj;
   logic [DW:0]   dstep1, dstep2;

   bx_adder #(.DW(DW), .NIB(NIB), .RIPPLE(RIPPLE)) u_add (
      .a     (add_a),
      .b     (add_b),
      .cin   (add_ci),
      .sum   (sum),
      .cout  (cout),
      .hcout (hcout),
      .ovf   (ovf)
   );

   // operand steering for the shared adder
   always_comb begin
      add_a  = fv;
      add_b  = wv;
      add_ci = 1'b0;
      case (op)
         OP_ADDC: add_ci = c_in;
         OP_SUB: begin
            add_b  = ~wv;
            add_ci = 1'b1;
         end
         OP_SUBB: begin
            add_b  = ~wv;
            add_ci = c_in;
         end
         OP_INC, OP_INCSZ, OP_INCSNZ: begin
            add_b  = '0;
            add_ci = 1'b1;
         end
         OP_DEC, OP_DECSZ, OP_DECSNZ: begin
            add_b  = '1;
            add_ci = 1'b0;
         end
         OP_NEG: begin
            add_a  = '0;
            add_b  = ~wv;
            add_ci = 1'b1;
         end
         default: ;
      endcase
   end

   // decimal adjust of WREG in two conditional steps
   always_comb begin
      lo_adj = (wv[NIB-1:0] > NIB_MAX) | dc_in;
      dstep1 = {1'b0, wv} + (lo_adj ? ADJ_LO : '0);
      hi_adj = (dstep1[DW-1:NIB] > NIB_MAX) | c_in | dstep1[DW];
      dstep2 = dstep1 + (hi_adj ? ADJ_HI : '0);
   end

   always_comb begin
      res       = fv;
      upd       = '0;
      flg       = '0;
      skip_cond = 1'b0;
      case (op)
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_INC, OP_DEC, OP_NEG: begin
            res    = sum;
            flg.c  = cout;
            flg.dc = hcout;
            flg.ov = ovf;
            upd    = '1;
         end
         OP_DECSZ, OP_INCSZ: begin
            res       = sum;
            skip_cond = (sum == '0);
         end
         OP_DECSNZ, OP_INCSNZ: begin
            res       = sum;
            skip_cond = (sum != '0);
         end
         OP_AND: begin
            res   = fv & wv;
            upd.z = 1'b1;
         end
         OP_IOR: begin
            res   = fv | wv;
            upd.z = 1'b1;
         end
         OP_COM: begin
            res   = ~fv;
            upd.z = 1'b1;
         end
         OP_SWAP:  res = {fv[NIB-1:0], fv[DW-1:NIB]};
         OP_RLC: begin
            res   = {fv[DW-2:0], c_in};
            flg.c = fv[DW-1];
            upd.c = 1'b1;
         end
         OP_RRC: begin
            res   = {c_in, fv[DW-1:1]};
            flg.c = fv[0];
            upd.c = 1'b1;
         end
         OP_RLN:   res = {fv[DW-2:0], fv[DW-1]};
         OP_RRN:   res = {fv[0], fv[DW-1:1]};
         OP_CPEQ:  skip_cond = (fv == wv);
         OP_CPGT:  skip_cond = (fv > wv);
         OP_CPLT:  skip_cond = (fv < wv);
         OP_CLR:   res = '0;
         OP_SET:   res = '1;
         OP_MOVWF: res = wv;
         OP_DAW: begin
            res   = dstep2[DW-1:0];
            flg.c = hi_adj;
            upd.c = 1'b1;
         end
         default: ;
      endcase
      flg.z = (res == '0);
   end

endmodule

// File: rtl/byte_exec_unit.sv
module byte_exec_unit
   import bx_pkg::*;
#(
   parameter int              DW         = 8,
   parameter logic [ADDR_W-1:0] WREG_ADDR = 8'h0A,
   parameter bit              HAS_DAW    = 1'b1,
   parameter bit              RIPPLE_ADD = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr,
   output logic [ADDR_W-1:0]  file_rd_addr,
   input  logic [DW-1:0]      file_rd_data,
   output logic               file_wr_en,
   output logic [ADDR_W-1:0]  file_wr_addr,
   output logic [DW-1:0]      file_wr_data,
   output logic [DW-1:0]      wreg_o,
   output logic [3:0]         status_o,
   output logic               skip_o,
   output logic               busy_o,
   output logic               unimpl_o
);

   generate
      if (DW != 8) begin : g_dw_bad
         $error("byte_exec_unit: DW must be 8 for nibble flags and decimal adjust");
      end
      if (INSTR_W != OPC_W + ADDR_W) begin : g_iw_bad
         $error("byte_exec_unit: instruction width must split into opcode and address");
      end
   endgenerate

   logic [OPC_W-1:0]  opc;
   logic [ADDR_W-1:0] faddr;
   logic              dbit;

   bx_op_e    op;
   bx_dst_e   dst;
   logic [DW-1:0] fv, res;
   bx_flags_t flg, upd;
   logic      skip_cond;

   logic [DW-1:0] wreg_q;
   bx_flags_t     status_q;
   logic          busy_q;

   logic exec, bad, commit, f_is_w;
   logic want_file, want_w;

   assign opc   = instr[INSTR_W-1:ADDR_W];
   assign faddr = instr[ADDR_W-1:0];
   assign dbit  = opc[0];

   assign file_rd_addr = faddr;
   assign f_is_w       = (faddr == WREG_ADDR);
   assign fv           = f_is_w ? wreg_q : file_rd_data;

   bx_decode #(.HAS_DAW(HAS_DAW)) u_dec (
      .opc (opc),
      .op  (op),
      .dst (dst)
   );

   bx_alu #(.DW(DW), .RIPPLE(RIPPLE_ADD)) u_alu (
      .op        (op),
      .fv        (fv),
      .wv        (wreg_q),
      .c_in      (status_q.c),
      .dc_in     (status_q.dc),
      .res       (res),
      .flg       (flg),
      .upd       (upd),
      .skip_cond (skip_cond)
   );

   always_comb begin
      want_file = 1'b0;
      want_w    = 1'b0;
      case (dst)
         DST_DFORM: begin
            want_file = dbit;
            want_w    = ~dbit;
         end
         DST_SFORM: begin
            want_file = 1'b1;
            want_w    = ~dbit;
         end
         DST_FILE:  want_file = 1'b1;
         default: ;
      endcase
   end

   assign exec   = instr_valid & ~busy_q;
   assign bad    = exec & (op == OP_BAD);
   assign commit = exec & (op != OP_BAD);

   assign file_wr_en   = commit & want_file & ~f_is_w;
   assign file_wr_addr = faddr;
   assign file_wr_data = res;
   assign skip_o       = commit & skip_cond;
   assign unimpl_o     = bad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wreg_q   <= '0;
         status_q <= '0;
         busy_q   <= 1'b0;
      end else begin
         busy_q <= skip_o;
         if (commit && (want_w || (want_file && f_is_w))) begin
            wreg_q <= res;
         end
         if (commit) begin
            status_q <= (status_q & ~upd) | (flg & upd);
         end
      end
   end

   assign wreg_o   = wreg_q;
   assign status_o = status_q;
   assign busy_o   = busy_q;

endmodule

// File: rtl/bx_exec_chk.sv
module bx_exec_chk #(
   parameter int          DW        = 8,
   parameter logic [7:0]  WREG_ADDR = 8'h0A
) (
   input logic          clk,
   input logic          rst_n,
   input logic          instr_valid,
   input logic [15:0]   instr,
   input logic          file_wr_en,
   input logic [7:0]    file_wr_addr,
   input logic [DW-1:0] wreg_o,
   input logic [3:0]    status_o,
   input logic          skip_o,
   input logic          busy_o,
   input logic          unimpl_o
);

   logic is_cmp;
   assign is_cmp = instr_valid && !busy_o &&
                   (instr[15:8] == 8'h30 || instr[15:8] == 8'h31 || instr[15:8] == 8'h32);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (wreg_o == '0) && (status_o == 4'h0) && !busy_o);

   // R9
   skip_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |=> busy_o);

   // R9
   busy_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !file_wr_en && !skip_o && !unimpl_o);

   // R9
   busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> !busy_o);

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(wreg_o) && $stable(status_o));

   // R13
   unimpl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unimpl_o |-> !file_wr_en && !skip_o);

   // R13
   unimpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unimpl_o |=> $stable(wreg_o) && $stable(status_o));

   // R12
   no_wreg_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      file_wr_en |-> file_wr_addr != WREG_ADDR);

   // R8
   cmp_no_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_cmp |-> !file_wr_en);

   // R8
   cmp_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_cmp |=> $stable(status_o) && $stable(wreg_o));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> !file_wr_en && !skip_o && !unimpl_o);

endmodule

bind byte_exec_unit bx_exec_chk #(.DW(DW), .WREG_ADDR(WREG_ADDR)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .instr_valid  (instr_valid),
   .instr        (instr),
   .file_wr_en   (file_wr_en),
   .file_wr_addr (file_wr_addr),
   .wreg_o       (wreg_o),
   .status_o     (status_o),
   .skip_o       (skip_o),
   .busy_o       (busy_o),
   .unimpl_o     (unimpl_o)
);

// File: tb/byte_exec_unit_tb.sv
module byte_exec_unit_tb;

   localparam int         CLK_PERIOD = 10;
   localparam logic [7:0] WA         = 8'h0A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr = 16'h0000;
   logic [7:0]  file_rd_addr;
   logic [7:0]  file_rd_data = 8'h00;
   logic        file_wr_en;
   logic [7:0]  file_wr_addr, file_wr_data, wreg_o;
   logic [3:0]  status_o;
   logic        skip_o, busy_o, unimpl_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_exec_unit #(.WREG_ADDR(WA)) u_dut (
      .clk, .rst_n, .instr_valid, .instr, .file_rd_addr, .file_rd_data,
      .file_wr_en, .file_wr_addr, .file_wr_data, .wreg_o, .status_o,
      .skip_o, .busy_o, .unimpl_o
   );

   typedef struct {
      logic       we;
      logic [7:0] wa;
      logic [7:0] wd;
      logic       sk;
      logic       un;
      logic [7:0] w;
      logic [3:0] st;
      logic       bz;
      string      req;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 1'b0;

   logic [7:0] mem [256];
   logic [7:0] m_w  = 8'h00;
   logic [3:0] m_st = 4'h0;   // {OV,Z,DC,C}
   logic       m_busy = 1'b0;

   // {ov, dc, c, sum}
   function automatic logic [10:0] addf(input logic [7:0] a, input logic [7:0] b, input logic ci);
      logic [8:0] s;
      logic [4:0] h;
      s = {1'b0, a} + {1'b0, b} + {8'h00, ci};
      h = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'h0, ci};
      return {((a[7] == b[7]) && (s[7] != a[7])), h[4], s[8], s[7:0]};
   endfunction

   task automatic issue(input logic [7:0] hi, input logic [7:0] f, input string req);
      exp_t e;
      logic [7:0]  fv, r;
      logic [3:0]  upd, nf;
      logic [10:0] a;
      logic [8:0]  t;
      logic        wf, ww, sk, bad, ar, lo, hia;
      @(negedge clk);
      instr_valid  = 1'b1;
      instr        = {hi, f};
      file_rd_data = mem[f];
      fv  = (f == WA) ? m_w : mem[f];
      r = 8'h00; upd = 4'h0; nf = 4'h0; a = '0; t = '0;
      wf = 0; ww = 0; sk = 0; bad = 0; ar = 0; lo = 0; hia = 0;
      e.we = 0; e.wa = 8'h00; e.wd = 8'h00; e.sk = 0; e.un = 0; e.req = req;
      if (m_busy) begin
         m_busy = 1'b0;            // R9 discarded slot
      end else begin
         casez (hi)
            8'h00: ;
            8'h01: begin r = m_w; wf = 1; end
            8'b0000_111?: begin a = addf(fv, m_w, 1'b0);    ar = 1; wf = hi[0]; ww = !hi[0]; end
            8'b0001_000?: begin a = addf(fv, m_w, m_st[0]); ar = 1; wf = hi[0]; ww = !hi[0]; end
            8'b0000_010?: begin a = addf(fv, ~m_w, 1'b1);   ar = 1; wf = hi[0]; ww = !hi[0]; end
            8'b0000_001?: begin a = addf(fv, ~m_w, m_st[0]); ar = 1; wf = hi[0]; ww = !hi[0]; end
            8'b0001_010?: begin a = addf(fv, 8'h00, 1'b1);  ar = 1; wf = hi[0]; ww = !hi[0]; end
            8'b0000_011?: begin a = addf(fv, 8'hFF, 1'b0);  ar = 1; wf = hi[0]; ww = !hi[0]; end
            8'b0000_101?: begin r = fv & m_w; upd = 4'b0100; wf = hi[0]; ww = !hi[0]; end
            8'b0000_100?: begin r = fv | m_w; upd = 4'b0100; wf = hi[0]; ww = !hi[0]; end
            8'b0001_001?: begin r = ~fv;      upd = 4'b0100; wf = hi[0]; ww = !hi[0]; end
            8'b0001_110?: begin r = {fv[3:0], fv[7:4]}; wf = hi[0]; ww = !hi[0]; end
            8'b0001_101?: begin r = {fv[6:0], m_st[0]}; nf[0] = fv[7]; upd = 4'b0001; wf = hi[0]; ww = !hi[0]; end
            8'b0001_100?: begin r = {m_st[0], fv[7:1]}; nf[0] = fv[0]; upd = 4'b0001; wf = hi[0]; ww = !hi[0]; end
            8'b0010_001?: begin r = {fv[6:0], fv[7]}; wf = hi[0]; ww = !hi[0]; end
            8'b0010_000?: begin r = {fv[0], fv[7:1]}; wf = hi[0]; ww = !hi[0]; end
            8'b0001_011?: begin r = fv - 8'd1; sk = (r == 0); wf = hi[0]; ww = !hi[0]; end
            8'b0010_011?: begin r = fv - 8'd1; sk = (r != 0); wf = hi[0]; ww = !hi[0]; end
            8'b0001_111?: begin r = fv + 8'd1; sk = (r == 0); wf = hi[0]; ww = !hi[0]; end
            8'b0010_010?: begin r = fv + 8'd1; sk = (r != 0); wf = hi[0]; ww = !hi[0]; end
            8'h31: sk = (fv == m_w);
            8'h32: sk = (fv > m_w);
            8'h30: sk = (fv < m_w);
            8'b0010_100?: begin r = 8'h00; wf = 1; ww = !hi[0]; end
            8'b0010_101?: begin r = 8'hFF; wf = 1; ww = !hi[0]; end
            8'b0010_110?: begin a = addf(8'h00, ~m_w, 1'b1); ar = 1; wf = 1; ww = !hi[0]; end
            8'b0010_111?: begin
               lo  = (m_w[3:0] > 4'd9) || m_st[1];
               t   = {1'b0, m_w} + (lo ? 9'h006 : 9'h000);
               hia = (t[7:4] > 4'd9) || m_st[0] || t[8];
               t   = t + (hia ? 9'h060 : 9'h000);
               r   = t[7:0]; nf[0] = hia; upd = 4'b0001; wf = 1; ww = !hi[0];
            end
            default: bad = 1;
         endcase
         if (ar) begin
            r = a[7:0]; nf = {a[10], 1'b0, a[9], a[8]}; upd = 4'hF;
         end
         nf[2] = (r == 8'h00);
         if (bad) begin
            e.un = 1'b1;
         end else begin
            if (wf && f == WA) ww = 1;
            if (wf && f != WA) begin
               e.we = 1; e.wa = f; e.wd = r; mem[f] = r;
            end
            if (ww) m_w = r;
            m_st = (m_st & ~upd) | (nf & upd);
            if (sk) begin e.sk = 1; m_busy = 1'b1; end
         end
      end
      e.w = m_w; e.st = m_st; e.bz = m_busy;
      q.push_back(e);
   endtask

   task automatic idle(input string req);
      exp_t e;
      @(negedge clk);
      instr_valid = 1'b0;
      instr       = 16'h1533;       // would increment if it were valid
      file_rd_data = mem[8'h33];
      e.we = 0; e.wa = 0; e.wd = 0; e.sk = 0; e.un = 0;
      m_busy = 1'b0;
      e.w = m_w; e.st = m_st; e.bz = m_busy; e.req = req;
      q.push_back(e);
   endtask

   task automatic set_w(input logic [7:0] v);
      mem[8'h20] = v;
      issue(8'h28, 8'h21, "R10");   // clear f and WREG
      issue(8'h08, 8'h20, "R5");    // WREG = f | 0
   endtask

   task automatic set_c(input logic b);
      mem[8'h22] = b ? 8'h01 : 8'h00;
      set_w(b ? 8'hFF : 8'h00);
      issue(8'h0F, 8'h22, "R4");
   endtask

   // monitor / scoreboard
   initial begin
      exp_t cur, prev;
      bit   have_prev;
      have_prev = 0;
      forever begin
         @(negedge clk);
         #1;
         if (have_prev) begin
            checks++;
            if (wreg_o !== prev.w || status_o !== prev.st || busy_o !== prev.bz) begin
               fails++;
               $display("FAIL %s state: wreg=%h status=%h busy=%b expected wreg=%h status=%h busy=%b",
                        prev.req, wreg_o, status_o, busy_o, prev.w, prev.st, prev.bz);
            end
         end
         if (q.size() > 0) begin
            cur = q.pop_front();
            checks++;
            if (file_wr_en !== cur.we || skip_o !== cur.sk || unimpl_o !== cur.un ||
                (cur.we && (file_wr_addr !== cur.wa || file_wr_data !== cur.wd))) begin
               fails++;
               $display("FAIL %s ports: we=%b wa=%h wd=%h skip=%b unimpl=%b expected we=%b wa=%h wd=%h skip=%b unimpl=%b",
                        cur.req, file_wr_en, file_wr_addr, file_wr_data, skip_o, unimpl_o,
                        cur.we, cur.wa, cur.wd, cur.sk, cur.un);
            end
            prev = cur;
            have_prev = 1;
         end else begin
            have_prev = 0;
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
      repeat (3) @(negedge clk);
      #1;
      checks++;   // R1 during reset
      if (wreg_o !== 8'h00 || status_o !== 4'h0 || busy_o !== 1'b0 || file_wr_en !== 1'b0) begin
         fails++;
         $display("FAIL R1: wreg=%h status=%h busy=%b we=%b expected 00 0 0 0",
                  wreg_o, status_o, busy_o, file_wr_en);
      end
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1");

      // R11
      issue(8'h00, 8'h40, "R11");
      issue(8'h01, 8'h41, "R11");

      // R4 add family
      set_w(8'h3C);
      mem[8'h30] = 8'hC8; issue(8'h0F, 8'h30, "R4");   // carry and half carry
      mem[8'h31] = 8'h7F; issue(8'h10, 8'h31, "R4");   // add with carry, overflow
      mem[8'h32] = 8'h10; issue(8'h05, 8'h32, "R4");   // borrow
      mem[8'h33] = 8'h80; issue(8'h02, 8'h33, "R4");   // with borrow in
      set_c(1'b1); set_w(8'h05);
      mem[8'h34] = 8'h05; issue(8'h03, 8'h34, "R4");   // f-W-0 = 0
      set_c(1'b0); set_w(8'h01);
      mem[8'h35] = 8'h05; issue(8'h02, 8'h35, "R4");   // f-W-1
      idle("R2");

      // R3 destination and R5 logic
      set_w(8'h5A);
      mem[8'h36] = 8'h0F; issue(8'h0B, 8'h36, "R3");
      mem[8'h37] = 8'hA5; issue(8'h0A, 8'h37, "R3");
      mem[8'h38] = 8'hA5; issue(8'h09, 8'h38, "R5");
      mem[8'h39] = 8'hFF; issue(8'h13, 8'h39, "R5");
      mem[8'h3A] = 8'h3C; issue(8'h12, 8'h3A, "R5");
      mem[8'h3B] = 8'h1E; issue(8'h1D, 8'h3B, "R5");

      // R6 increment/decrement edges
      mem[8'h3C] = 8'hFF; issue(8'h15, 8'h3C, "R6");
      mem[8'h3D] = 8'h00; issue(8'h07, 8'h3D, "R6");
      mem[8'h3E] = 8'h7F; issue(8'h14, 8'h3E, "R6");
      mem[8'h3F] = 8'h80; issue(8'h07, 8'h3F, "R6");
      mem[8'h43] = 8'h0F; issue(8'h15, 8'h43, "R6");

      // R7 rotates
      set_c(1'b0);
      mem[8'h44] = 8'h81; issue(8'h1B, 8'h44, "R7");
      mem[8'h45] = 8'h02; issue(8'h19, 8'h45, "R7");
      mem[8'h46] = 8'h01; issue(8'h18, 8'h46, "R7");
      mem[8'h47] = 8'h81; issue(8'h23, 8'h47, "R7");
      mem[8'h48] = 8'h81; issue(8'h20, 8'h48, "R7");

      // R8/R9 skips
      mem[8'h50] = 8'h01; issue(8'h17, 8'h50, "R8");
      mem[8'h51] = 8'h10; issue(8'h15, 8'h51, "R9");   // discarded
      mem[8'h52] = 8'h05; issue(8'h17, 8'h52, "R8");   // no skip
      mem[8'h53] = 8'hFF; issue(8'h1F, 8'h53, "R8");
      mem[8'h53] = 8'h00; issue(8'h1F, 8'h53, "R9");   // second skip discarded
      issue(8'h0E, 8'h53, "R9");
      mem[8'h54] = 8'h03; issue(8'h27, 8'h54, "R8");
      issue(8'hFF, 8'h00, "R9");                       // unknown while busy
      mem[8'h55] = 8'h01; issue(8'h26, 8'h55, "R8");   // result 0, no skip
      mem[8'h56] = 8'hFF; issue(8'h25, 8'h56, "R8");   // result 0, no skip
      mem[8'h57] = 8'h10; issue(8'h24, 8'h57, "R8");
      idle("R9");
      set_w(8'h40);
      mem[8'h58] = 8'h40; issue(8'h31, 8'h58, "R8");
      issue(8'h29, 8'h59, "R9");
      issue(8'h32, 8'h58, "R8");                       // equal: no skip
      issue(8'h30, 8'h58, "R8");                       // equal: no skip
      mem[8'h59] = 8'h41; issue(8'h32, 8'h59, "R8");
      issue(8'h01, 8'h60, "R9");
      mem[8'h5A] = 8'h3F; issue(8'h30, 8'h5A, "R8");
      issue(8'h31, 8'h5A, "R8");

      // R10 s-form
      issue(8'h29, 8'h61, "R10");
      issue(8'h2A, 8'h62, "R10");
      set_w(8'h80); issue(8'h2C, 8'h63, "R10");        // overflow
      set_w(8'h00); issue(8'h2D, 8'h64, "R10");        // zero, no borrow
      set_w(8'h01); issue(8'h2D, 8'h65, "R10");

      // R14 decimal adjust
      set_c(1'b0); set_w(8'h9A); issue(8'h2E, 8'h66, "R14");
      set_c(1'b0); set_w(8'h15); issue(8'h2E, 8'h67, "R14");
      set_c(1'b0); set_w(8'h09);
      mem[8'h68] = 8'h09; issue(8'h0E, 8'h68, "R14");  // 0x12, DC=1
      issue(8'h2F, 8'h69, "R14");
      set_c(1'b1); set_w(8'h23); issue(8'h2E, 8'h6A, "R14");

      // R12 WREG as file
      set_w(8'h21);
      issue(8'h0F, WA, "R12");
      issue(8'h14, WA, "R12");
      issue(8'h29, WA, "R12");
      set_w(8'h33);
      issue(8'h1F, WA, "R12");
      issue(8'h31, WA, "R12");
      issue(8'h15, 8'h70, "R9");

      // R13 unknown opcodes
      issue(8'h0C, 8'h71, "R13");
      issue(8'h0D, 8'h71, "R13");
      issue(8'h33, 8'h71, "R13");
      issue(8'h34, 8'h71, "R13");
      issue(8'h40, 8'h71, "R13");
      issue(8'hFF, 8'h71, "R13");

      idle("R2");
      idle("R2");
      @(negedge clk);
      @(negedge clk);
      #2;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule